// File: doc/BRIEF.md
# Four-Axis Counter Host Register Interface and Interrupt Controller

This block is the host-facing side of a four-axis counter. A host drives an 8-bit parallel bus with an active-low chip select, active-low read and write strobes, a 3-bit register select and a 2-bit axis select. A write is committed inside the system clock domain when the synchronized write strobe ends. Reads are combinational from the pins, and the bus driver is enabled only while a read is in progress.

Per axis, the block holds two 8-bit mode registers. Preset-byte and command writes go out as one-cycle pulses to the counter logic. Status bytes and the 24-bit output latch come in from the counter as ports. The block also holds a global 4-bit interrupt mask and a 4-bit interrupt status register. The falling edge of each axis's flag-A input sets the matching status bit. A single active-low interrupt line reports whether any status bit is set. The tristate pad sits at the chip edge and is controlled by `bus_drive_en`.

Top module: `axis_host_regs`

## Requirements
- R1: After reset the mask, interrupt status and all mode registers are 0, `irq_n` is 1, no pulse outputs are active and `bus_drive_en` is 0.
- R2: `bus_drive_en` is 1 only while `cs_n` and `rd_n` are both 0 and `reg_sel` is not 7.
- R3: Read data by `reg_sel` for the axis chosen by `axis_sel`: 0 gives {status[3:0], mask[3:0]}, 1 gives mode register 0, 2 gives mode register 1, 3 gives that axis's status byte, and 4, 5 and 6 give latch bits 7:0, 15:8 and 23:16. Select 7 leaves the bus undriven.
- R4: Writes with `reg_sel` 1 or 2 load mode register 0 or 1 of the selected axis only. The write commits when the two-flop synchronized strobe (`cs_n` and `wr_n` both low) ends.
- R5: A write with `reg_sel` 0 stores data bits 3:0 into the global mask and ignores bits 7:4.
- R6: Writes with `reg_sel` 4, 5 and 6 give a one-cycle `preset_wr` pulse on the selected axis bit, with `preset_byte` set to 0, 1 and 2 and `wr_byte` holding the data. A write with `reg_sel` 7 gives a one-cycle `cmd_wr` pulse on the selected axis bit, with `wr_byte` holding the data.
- R7: A write with `reg_sel` 3 has no effect: no pulse is produced, and the mask and mode registers do not change.
- R8: An interrupt status bit sets on a 1-to-0 transition of that axis's `flag_a` only if the matching mask bit is 1. A `flag_a` held low does not set it again.
- R9: `irq_n` is 0 exactly when at least one interrupt status bit is 1.
- R10: A command write with data bit 7 set clears the interrupt status bit of the selected axis and leaves the other bits alone.
- R11: A command write with data bit 4 set (master reset) clears the mask, every interrupt status bit and both mode registers of the selected axis.
- R12: If a flag-A falling edge on a masked-in axis arrives in the same cycle as a clear of that axis's status bit, the bit ends up set.
- R13: Write strobes given while `cs_n` is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_sel | input | 3 | Register select |
| axis_sel | input | 2 | Axis select |
| bus_wr_data | input | 8 | Data from the host bus |
| bus_rd_data | output | 8 | Data to the host bus |
| bus_drive_en | output | 1 | Pad output enable for the bus |
| axis_status | input | 32 | Status byte per axis, axis n at bits 8n+7:8n |
| axis_latch | input | 96 | Output latch per axis, axis n at bits 24n+23:24n |
| flag_a | input | 4 | Flag-A level per axis, idle high |
| mode0_flat | output | 32 | Mode register 0 per axis, axis n at bits 8n+7:8n |
| mode1_flat | output | 32 | Mode register 1 per axis, axis n at bits 8n+7:8n |
| preset_wr | output | 4 | Preset byte write pulse per axis |
| preset_byte | output | 2 | Index of the preset byte being written |
| cmd_wr | output | 4 | Command write pulse per axis |
| wr_byte | output | 8 | Data that goes with a pulse |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The bench targets the collision in which a flag-A fall lands in the same cycle as a committed clear. A design that let the clear win would lose the interrupt, and `irq_n` would go back high. It also targets the reserved write select 3 and strobes given without chip select: a decoder with loose address handling would produce a pulse or corrupt a mode register. Other checks cover a flag held low, which must not set the status bit again, and a masked-out axis, which must never raise the line. Master reset must clear only the addressed axis's modes. A read at select 7 must leave the bus released, and a design that drove a stale byte there would fail.

// File: rtl/axis_host_pkg.sv
package axis_host_pkg;

    localparam int DATA_W     = 8;
    localparam int AXIS_SEL_W = 2;
    localparam int NUM_AXES   = 1 << AXIS_SEL_W;
    localparam int REG_SEL_W  = 3;
    localparam int MASK_W     = NUM_AXES;
    localparam int LATCH_W    = 24;
    localparam int LATCH_BYTES = LATCH_W / DATA_W;

    localparam int CMD_MASTER_BIT = 4;
    localparam int CMD_INTCLR_BIT = 7;

    typedef enum logic [REG_SEL_W-1:0] {
        RD_INTR  = 3'd0,
        RD_MODE0 = 3'd1,
        RD_MODE1 = 3'd2,
        RD_STAT  = 3'd3,
        RD_LAT0  = 3'd4,
        RD_LAT1  = 3'd5,
        RD_LAT2  = 3'd6,
        RD_NONE  = 3'd7
    } rd_addr_e;

    typedef enum logic [REG_SEL_W-1:0] {
        WR_MASK  = 3'd0,
        WR_MODE0 = 3'd1,
        WR_MODE1 = 3'd2,
        WR_NONE  = 3'd3,
        WR_PRE0  = 3'd4,
        WR_PRE1  = 3'd5,
        WR_PRE2  = 3'd6,
        WR_CMD   = 3'd7
    } wr_addr_e;

    typedef struct packed {
        wr_addr_e                sel;
        logic [AXIS_SEL_W-1:0]   axis;
        logic [DATA_W-1:0]       data;
    } host_wr_t;

    function automatic logic is_preset(wr_addr_e s);
        return (s == WR_PRE0) || (s == WR_PRE1) || (s == WR_PRE2);
    endfunction

    function automatic logic [1:0] preset_slot(wr_addr_e s);
        return s[1:0];
    endfunction

    function automatic logic [NUM_AXES-1:0] axis_onehot(logic [AXIS_SEL_W-1:0] a);
        return NUM_AXES'(1) << a;
    endfunction

endpackage

// File: rtl/host_strobe_sync.sv
module host_strobe_sync
    import axis_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic [REG_SEL_W-1:0]  reg_sel,
    input  logic [AXIS_SEL_W-1:0] axis_sel,
    input  logic [DATA_W-1:0]     bus_wr_data,
    output host_wr_t              wr_req,
    output logic                  commit
);

    logic                 wr_act;
    logic [SYNC_STAGES:0] chain;

    assign wr_act = ~cs_n & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], wr_act};
        end
    end

    // capture address and data while the synchronized strobe is high
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_req <= '0;
        end else if (chain[SYNC_STAGES-1]) begin
            wr_req.sel  <= wr_addr_e'(reg_sel);
            wr_req.axis <= axis_sel;
            wr_req.data <= bus_wr_data;
        end
    end

    assign commit = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

    a_r4_single_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

endmodule

// File: rtl/host_wr_decode.sv
module host_wr_decode
    import axis_host_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  host_wr_t             wr_req,
    output logic [DATA_W-1:0]    mode0_q [NUM_AXES],
    output logic [DATA_W-1:0]    mode1_q [NUM_AXES],
    output logic [MASK_W-1:0]    mask_q,
    output logic [NUM_AXES-1:0]  intr_clr,
    output logic                 master_clr,
    output logic [NUM_AXES-1:0]  preset_wr,
    output logic [1:0]           preset_byte,
    output logic [NUM_AXES-1:0]  cmd_wr,
    output logic [DATA_W-1:0]    wr_byte
);

    logic [NUM_AXES-1:0] axis_hit;
    logic                is_cmd;

    always_comb begin
        axis_hit   = commit ? axis_onehot(wr_req.axis) : '0;
        is_cmd     = commit && (wr_req.sel == WR_CMD);
        master_clr = is_cmd && wr_req.data[CMD_MASTER_BIT];
        intr_clr   = (is_cmd && wr_req.data[CMD_INTCLR_BIT]) ? axis_hit : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < NUM_AXES; a++) begin
                mode0_q[a] <= '0;
                mode1_q[a] <= '0;
            end
        end else begin
            for (int a = 0; a < NUM_AXES; a++) begin
                if (master_clr && axis_hit[a]) begin
                    mode0_q[a] <= '0;
                    mode1_q[a] <= '0;
                end else if (axis_hit[a]) begin
                    if (wr_req.sel == WR_MODE0) mode0_q[a] <= wr_req.data;
                    if (wr_req.sel == WR_MODE1) mode1_q[a] <= wr_req.data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || master_clr) begin
            mask_q <= '0;
        end else if (commit && wr_req.sel == WR_MASK) begin
            mask_q <= wr_req.data[MASK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            preset_wr   <= '0;
            preset_byte <= '0;
            cmd_wr      <= '0;
            wr_byte     <= '0;
        end else begin
            preset_wr <= is_preset(wr_req.sel) ? axis_hit : '0;
            cmd_wr    <= is_cmd ? axis_hit : '0;
            if (commit) begin
                preset_byte <= preset_slot(wr_req.sel);
                wr_byte     <= wr_req.data;
            end
        end
    end

    a_r6_pulse_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(preset_wr) && $onehot0(cmd_wr) && !(|preset_wr && |cmd_wr));

    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (commit && wr_req.sel == WR_NONE) |=>
            (preset_wr == '0) && (cmd_wr == '0) && (mask_q == $past(mask_q)));

    a_r11_master_mask: assert property (@(posedge clk) disable iff (rst)
        master_clr |=> (mask_q == '0));

endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
    import axis_host_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_AXES-1:0]  flag_a,
    input  logic [MASK_W-1:0]    mask_q,
    input  logic [NUM_AXES-1:0]  intr_clr,
    input  logic                 master_clr,
    output logic [NUM_AXES-1:0]  isr_q,
    output logic                 irq_n
);

    logic [NUM_AXES-1:0] flag_prev;
    logic [NUM_AXES-1:0] fall;
    logic [NUM_AXES-1:0] set_req;
    logic [NUM_AXES-1:0] keep;
    logic [NUM_AXES-1:0] isr_next;

    always_comb begin
        fall     = flag_prev & ~flag_a;
        set_req  = fall & mask_q;
        keep     = isr_q & ~intr_clr & {NUM_AXES{~master_clr}};
        isr_next = set_req | keep;   // set has priority over any clear
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_prev <= '1;
            isr_q     <= '0;
            irq_n     <= 1'b1;
        end else begin
            flag_prev <= flag_a;
            isr_q     <= isr_next;
            irq_n     <= ~(|isr_next);
        end
    end

    a_r9_line_matches: assert property (@(posedge clk) disable iff (rst)
        (isr_q != '0) == !irq_n);

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis_chk
        a_r8_set_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(isr_q[g]) |-> $past(mask_q[g] && !flag_a[g]));

        a_r10_clear_bit: assert property (@(posedge clk) disable iff (rst)
            (intr_clr[g] && !fall[g]) |=> !isr_q[g]);

        a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
            (intr_clr[g] && fall[g] && mask_q[g]) |=> isr_q[g]);
    end

endmodule

// File: rtl/host_rd_mux.sv
module host_rd_mux
    import axis_host_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          rd_n,
    input  logic [REG_SEL_W-1:0]          reg_sel,
    input  logic [AXIS_SEL_W-1:0]         axis_sel,
    input  logic [DATA_W-1:0]             mode0_q [NUM_AXES],
    input  logic [DATA_W-1:0]             mode1_q [NUM_AXES],
    input  logic [MASK_W-1:0]             mask_q,
    input  logic [NUM_AXES-1:0]           isr_q,
    input  logic [NUM_AXES*DATA_W-1:0]    axis_status,
    input  logic [NUM_AXES*LATCH_W-1:0]   axis_latch,
    output logic [DATA_W-1:0]             bus_rd_data,
    output logic                          bus_drive_en
);

    rd_addr_e            rsel;
    logic [LATCH_W-1:0]  lat_word;

    assign rsel     = rd_addr_e'(reg_sel);
    assign lat_word = axis_latch[axis_sel*LATCH_W +: LATCH_W];

    always_comb begin
        bus_rd_data = '0;
        case (rsel)
            RD_INTR:  bus_rd_data = {isr_q, mask_q};
            RD_MODE0: bus_rd_data = mode0_q[axis_sel];
            RD_MODE1: bus_rd_data = mode1_q[axis_sel];
            RD_STAT:  bus_rd_data = axis_status[axis_sel*DATA_W +: DATA_W];
            RD_LAT0:  bus_rd_data = lat_word[0*DATA_W +: DATA_W];
            RD_LAT1:  bus_rd_data = lat_word[1*DATA_W +: DATA_W];
            RD_LAT2:  bus_rd_data = lat_word[2*DATA_W +: DATA_W];
            default:  bus_rd_data = '0;
        endcase
        bus_drive_en = ~cs_n & ~rd_n & (rsel != RD_NONE);
    end

    a_r2_drive_needs_strobes: assert property (@(posedge clk) disable iff (rst)
        bus_drive_en |-> (!cs_n && !rd_n && reg_sel != 3'd7));

endmodule

// File: rtl/axis_host_regs.sv
module axis_host_regs
    import axis_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          rd_n,
    input  logic                          wr_n,
    input  logic [REG_SEL_W-1:0]          reg_sel,
    input  logic [AXIS_SEL_W-1:0]         axis_sel,
    input  logic [DATA_W-1:0]             bus_wr_data,
    output logic [DATA_W-1:0]             bus_rd_data,
    output logic                          bus_drive_en,
    input  logic [NUM_AXES*DATA_W-1:0]    axis_status,
    input  logic [NUM_AXES*LATCH_W-1:0]   axis_latch,
    input  logic [NUM_AXES-1:0]           flag_a,
    output logic [NUM_AXES*DATA_W-1:0]    mode0_flat,
    output logic [NUM_AXES*DATA_W-1:0]    mode1_flat,
    output logic [NUM_AXES-1:0]           preset_wr,
    output logic [1:0]                    preset_byte,
    output logic [NUM_AXES-1:0]           cmd_wr,
    output logic [DATA_W-1:0]             wr_byte,
    output logic                          irq_n
);

    host_wr_t             wr_req;
    logic                 commit;
    logic [DATA_W-1:0]    mode0_q [NUM_AXES];
    logic [DATA_W-1:0]    mode1_q [NUM_AXES];
    logic [MASK_W-1:0]    mask_q;
    logic [NUM_AXES-1:0]  intr_clr;
    logic                 master_clr;
    logic [NUM_AXES-1:0]  isr_q;

    host_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .wr_n        (wr_n),
        .reg_sel     (reg_sel),
        .axis_sel    (axis_sel),
        .bus_wr_data (bus_wr_data),
        .wr_req      (wr_req),
        .commit      (commit)
    );

    host_wr_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .wr_req      (wr_req),
        .mode0_q     (mode0_q),
        .mode1_q     (mode1_q),
        .mask_q      (mask_q),
        .intr_clr    (intr_clr),
        .master_clr  (master_clr),
        .preset_wr   (preset_wr),
        .preset_byte (preset_byte),
        .cmd_wr      (cmd_wr),
        .wr_byte     (wr_byte)
    );

    intr_ctrl u_intr (
        .clk        (clk),
        .rst        (rst),
        .flag_a     (flag_a),
        .mask_q     (mask_q),
        .intr_clr   (intr_clr),
        .master_clr (master_clr),
        .isr_q      (isr_q),
        .irq_n      (irq_n)
    );

    host_rd_mux u_rd (
        .clk          (clk),
        .rst          (rst),
        .cs_n         (cs_n),
        .rd_n         (rd_n),
        .reg_sel      (reg_sel),
        .axis_sel     (axis_sel),
        .mode0_q      (mode0_q),
        .mode1_q      (mode1_q),
        .mask_q       (mask_q),
        .isr_q        (isr_q),
        .axis_status  (axis_status),
        .axis_latch   (axis_latch),
        .bus_rd_data  (bus_rd_data),
        .bus_drive_en (bus_drive_en)
    );

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_flat
        assign mode0_flat[g*DATA_W +: DATA_W] = mode0_q[g];
        assign mode1_flat[g*DATA_W +: DATA_W] = mode1_q[g];
    end

endmodule

// File: tb/axis_host_regs_test.sv
module axis_host_regs_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, rd_n, wr_n;
    logic [2:0]  reg_sel;
    logic [1:0]  axis_sel;
    logic [7:0]  bus_wr_data;
    logic [7:0]  bus_rd_data;
    logic        bus_drive_en;
    logic [31:0] axis_status;
    logic [95:0] axis_latch;
    logic [3:0]  flag_a;
    logic [31:0] mode0_flat, mode1_flat;
    logic [3:0]  preset_wr;
    logic [1:0]  preset_byte;
    logic [3:0]  cmd_wr;
    logic [7:0]  wr_byte;
    logic        irq_n;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] m_mode0 [4];
    logic [7:0] m_mode1 [4];
    logic [3:0] m_mask;
    logic [3:0] m_isr;

    logic [3:0] seen_preset, seen_cmd;
    logic [1:0] seen_pbyte;
    logic [7:0] seen_data;

    always #4 clk = ~clk;   // 125 MHz

    axis_host_regs uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .reg_sel(reg_sel), .axis_sel(axis_sel), .bus_wr_data(bus_wr_data),
        .bus_rd_data(bus_rd_data), .bus_drive_en(bus_drive_en),
        .axis_status(axis_status), .axis_latch(axis_latch), .flag_a(flag_a),
        .mode0_flat(mode0_flat), .mode1_flat(mode1_flat),
        .preset_wr(preset_wr), .preset_byte(preset_byte), .cmd_wr(cmd_wr),
        .wr_byte(wr_byte), .irq_n(irq_n)
    );

    function automatic logic [7:0] stat_pat(int a);
        return 8'h30 + 8'(a * 17);
    endfunction

    function automatic logic [7:0] lat_pat(int a, int b);
        return {2'(a), 2'(b), 4'h9};
    endfunction

    function automatic logic [8:0] exp_read(int sel, int a);
        case (sel)
            0: return {1'b1, m_isr, m_mask};
            1: return {1'b1, m_mode0[a]};
            2: return {1'b1, m_mode1[a]};
            3: return {1'b1, stat_pat(a)};
            4, 5, 6: return {1'b1, lat_pat(a, sel - 4)};
            default: return 9'h000;
        endcase
    endfunction

    always @(negedge clk) begin
        if (preset_wr != 4'h0) begin
            seen_preset = seen_preset | preset_wr;
            seen_pbyte  = preset_byte;
            seen_data   = wr_byte;
        end
        if (cmd_wr != 4'h0) begin
            seen_cmd  = seen_cmd | cmd_wr;
            seen_data = wr_byte;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] sel, input int a, input logic [7:0] d,
                              input bit use_cs, input int fall_axis);
        seen_preset = 4'h0; seen_cmd = 4'h0;
        @(negedge clk);
        reg_sel = sel; axis_sel = 2'(a); bus_wr_data = d;
        cs_n = !use_cs; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (2) @(negedge clk);
        if (fall_axis >= 0) flag_a[fall_axis] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(input int sel, input int a, output logic [8:0] got);
        @(negedge clk);
        reg_sel = 3'(sel); axis_sel = 2'(a); cs_n = 1'b0; rd_n = 1'b0;
        #2;
        got = {bus_drive_en, bus_rd_data};
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic check_read(input string req, input int sel, input int a);
        logic [8:0] got, exp;
        host_read(sel, a, got);
        exp = exp_read(sel, a);
        if (sel == 7) check(req, 32'(got[8]), 32'(0));
        else check(req, 32'(got), 32'(exp));
    endtask

    task automatic flag_pulse(input int a);
        @(negedge clk);
        flag_a[a] = 1'b0;
        repeat (2) @(negedge clk);
        flag_a[a] = 1'b1;
        repeat (2) @(negedge clk);
        if (m_mask[a]) m_isr[a] = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        logic [8:0] got;
        int seed;
        seed = $urandom(32'd2024);
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        reg_sel = 3'd0; axis_sel = 2'd0; bus_wr_data = 8'h00; flag_a = 4'hF;
        seen_preset = 4'h0; seen_cmd = 4'h0; seen_pbyte = 2'd0; seen_data = 8'h00;
        for (int a = 0; a < 4; a++) begin
            axis_status[a*8 +: 8] = stat_pat(a);
            for (int b = 0; b < 3; b++) axis_latch[a*24 + b*8 +: 8] = lat_pat(a, b);
            m_mode0[a] = 8'h00; m_mode1[a] = 8'h00;
        end
        m_mask = 4'h0; m_isr = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_n", 32'(irq_n), 32'(1));
        check("R1 drive_en", 32'(bus_drive_en), 32'(0));
        check("R1 modes", 32'({mode0_flat, mode1_flat} == 64'h0), 32'(1));
        check("R1 pulses", 32'({preset_wr, cmd_wr}), 32'(0));
        check_read("R1 intr read", 0, 0);

        // R2 driver enable needs both strobes
        @(negedge clk); reg_sel = 3'd1; cs_n = 1'b1; rd_n = 1'b0; #2;
        check("R2 cs high", 32'(bus_drive_en), 32'(0));
        cs_n = 1'b0; rd_n = 1'b1; #2;
        check("R2 rd high", 32'(bus_drive_en), 32'(0));
        cs_n = 1'b1;

        // R3 read map
        for (int s = 0; s < 8; s++) check_read("R3 map", s, 2);
        check_read("R3 latch axis3", 6, 3);

        // R4 mode writes
        host_write(3'd1, 1, 8'h5A, 1'b1, -1); m_mode0[1] = 8'h5A;
        host_write(3'd2, 3, 8'hC3, 1'b1, -1); m_mode1[3] = 8'hC3;
        check("R4 mode0 ax1 port", 32'(mode0_flat[15:8]), 32'(8'h5A));
        check("R4 mode0 ax0 untouched", 32'(mode0_flat[7:0]), 32'(0));
        check_read("R4 mode1 ax3", 2, 3);
        check_read("R4 mode0 ax1", 1, 1);

        // R5 mask keeps low nibble
        host_write(3'd0, 2, 8'hF5, 1'b1, -1); m_mask = 4'h5;
        check_read("R5 mask", 0, 0);

        // R6 preset and command pulses
        host_write(3'd5, 2, 8'h7E, 1'b1, -1);
        check("R6 preset axis", 32'(seen_preset), 32'(4'b0100));
        check("R6 preset byte", 32'(seen_pbyte), 32'(1));
        check("R6 preset data", 32'(seen_data), 32'(8'h7E));
        host_write(3'd6, 0, 8'h11, 1'b1, -1);
        check("R6 preset byte2", 32'({seen_preset, seen_pbyte}), 32'({4'b0001, 2'd2}));
        host_write(3'd7, 3, 8'h01, 1'b1, -1);
        check("R6 cmd axis", 32'(seen_cmd), 32'(4'b1000));
        check("R6 cmd data", 32'(seen_data), 32'(8'h01));

        // R7 reserved write select
        host_write(3'd3, 1, 8'hFF, 1'b1, -1);
        check("R7 no pulse", 32'({seen_preset, seen_cmd}), 32'(0));
        check("R7 modes", 32'({mode0_flat, mode1_flat}), 32'({8'h00, 8'h00, 8'h5A, 8'h00, 8'hC3, 24'h0}));
        check_read("R7 mask", 0, 0);

        // R13 strobe without chip select
        host_write(3'd1, 0, 8'h99, 1'b0, -1);
        host_write(3'd5, 0, 8'h99, 1'b0, -1);
        check("R13 no pulse", 32'(seen_preset), 32'(0));
        check_read("R13 mode0 ax0", 1, 0);

        // R8 masked set, held low, masked off axis
        flag_pulse(1);
        check("R8 masked off", 32'({m_isr, irq_n}), 32'({4'h0, 1'b1}));
        check_read("R8 isr after masked", 0, 0);
        @(negedge clk); flag_a[0] = 1'b0;
        repeat (3) @(negedge clk);
        m_isr[0] = 1'b1;
        check("R9 irq low", 32'(irq_n), 32'(0));
        check_read("R8 isr set", 0, 0);
        host_write(3'd7, 0, 8'h80, 1'b1, -1); m_isr[0] = 1'b0;
        check_read("R8 held low no reset", 0, 0);
        check("R9 irq high", 32'(irq_n), 32'(1));
        @(negedge clk); flag_a[0] = 1'b1;

        // R10 per-axis clear
        flag_pulse(0); flag_pulse(2);
        check_read("R10 both set", 0, 0);
        host_write(3'd7, 2, 8'h80, 1'b1, -1); m_isr[2] = 1'b0;
        check_read("R10 clear ax2 only", 0, 0);
        host_write(3'd7, 1, 8'h80, 1'b1, -1);
        check_read("R10 clear of unset axis", 0, 0);

        // R12 set beats clear in same cycle
        host_write(3'd7, 0, 8'h80, 1'b1, 0); m_isr[0] = 1'b1;
        check_read("R12 set wins", 0, 0);
        check("R12 irq", 32'(irq_n), 32'(0));
        @(negedge clk); flag_a[0] = 1'b1;

        // R11 master reset
        host_write(3'd1, 3, 8'h44, 1'b1, -1); m_mode0[3] = 8'h44;
        host_write(3'd7, 1, 8'h10, 1'b1, -1);
        m_mask = 4'h0; m_isr = 4'h0; m_mode0[1] = 8'h00; m_mode1[1] = 8'h00;
        check_read("R11 mask isr", 0, 0);
        check("R11 irq", 32'(irq_n), 32'(1));
        check_read("R11 ax1 mode0", 1, 1);
        check_read("R11 ax3 mode0 kept", 1, 3);
        check_read("R11 ax3 mode1 kept", 2, 3);

        // random mix (R3 R4 R5 R8 R9 R10)
        for (int i = 0; i < 120; i++) begin
            int op, a;
            logic [7:0] d;
            op = $urandom_range(0, 5);
            a  = $urandom_range(0, 3);
            d  = 8'($urandom);
            case (op)
                0: begin host_write(3'd1, a, d, 1'b1, -1); m_mode0[a] = d; end
                1: begin host_write(3'd2, a, d, 1'b1, -1); m_mode1[a] = d; end
                2: begin host_write(3'd0, a, d, 1'b1, -1); m_mask = d[3:0]; end
                3: flag_pulse(a);
                4: begin host_write(3'd7, a, 8'h80 | (d & 8'h6F), 1'b1, -1); m_isr[a] = 1'b0; end
                default: check_read("R3 random read", $urandom_range(0, 6), a);
            endcase
            check("R9 random irq", 32'(irq_n), 32'(m_isr == 4'h0));
        end
        for (int a = 0; a < 4; a++) begin
            check_read("R4 final mode0", 1, a);
            check_read("R4 final mode1", 2, a);
        end
        check_read("R5 final intr", 0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule